// File: doc/BRIEF.md
# TPM Register-Bus SPI Host with Wait-State Polling

This block is the host side of a register transaction to a TPM over SPI. A single request names the direction, a 16-bit register offset inside the locality space and a length of 1 to 64 bytes. The engine drops chip select and sends a four-byte command header. It then clocks single poll bytes until the device shows readiness. Only after that does it move the data: it sends write bytes taken from an input stream, or it captures read bytes into an output stream.

Readiness is bit 0 of a byte returned during the poll phase. The value on MISO while the header is still being shifted out is never looked at. This holds even when the device already shows the ready bit on the last header byte, so at least one poll byte always follows the header. Polling is bounded by a cycle-counted timeout, which ends the transaction with a busy code. A fault indication from the link layer, sampled as each poll byte completes, also ends it, with a fault code. Every transaction finishes with chip select released, followed by a one-cycle completion pulse that carries the result code.

Top module: `regbus_spi_host`

## Requirements
- R1: Header byte 0 carries the direction in bit 7 (1 = read, 0 = write), a 0 in bit 6 and the length minus one in bits 5:0.
- R2: Header bytes 1, 2 and 3 are the fixed upper address byte 0xD4, then offset bits 15:8, then offset bits 7:0.
- R3: The serial timing follows SPI mode 0. SCLK idles low and is low whenever csN is high. MOSI changes only while SCLK is low, and stays stable through each high phase. MISO is sampled on the rising edge, with the most significant bit first.
- R4: After the header, the engine clocks single poll bytes with MOSI = 0x00. Polling ends on the first poll byte whose bit 0 is 1. Bits 7:1 of a poll byte are ignored, so 0xFE means not ready.
- R5: Bit 0 returned during any header byte has no effect. At least one poll byte always follows the header, and data starts only after a ready poll byte.
- R6: A read moves exactly the requested number of data bytes with MOSI = 0x00. Each received byte appears on rdData together with a one-cycle rdValid pulse.
- R7: A write moves exactly the requested number of data bytes. Each byte comes from wrData in the cycle wrTake pulses, once per byte.
- R8: The timeout counter starts with polling and counts system clock cycles. Poll byte k completes k*(16*CLK_DIV+2)-1 cycles after polling starts. A poll byte that completes at or after TIMEOUT_CYC cycles aborts the transaction with error code 1 and no data bytes. This applies even if that byte has bit 0 set.
- R9: If linkFault is high when a poll byte completes, the transaction aborts with error code 2. This takes precedence over both readiness and timeout.
- R10: doneP is a one-cycle pulse in the cycle after csN returns high. errCode is 0 for success, 1 for busy timeout and 2 for fault, and it holds its value from doneP until the next request.
- R11: During and after reset, csN is high, SCLK is low, and busy and doneP are low.
- R12: A start pulse while busy is high is ignored. It does not alter the running transaction and does not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted while idle |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqAddr | input | 16 | Register offset inside the locality space |
| reqLen | input | 7 | Byte count, 1 to 64 |
| wrData | input | 8 | Write byte, consumed when wrTake pulses |
| wrTake | output | 1 | Pulse: wrData is taken this cycle |
| rdData | output | 8 | Read byte, valid with rdValid |
| rdValid | output | 1 | Pulse: a read byte is on rdData |
| linkFault | input | 1 | Link fault, checked as each poll byte ends |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data to the device |
| csN | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data from the device |
| busy | output | 1 | A transaction is in progress |
| doneP | output | 1 | Completion pulse after chip select release |
| errCode | output | 2 | Result: 0 ok, 1 busy timeout, 2 fault |

## Verification
Two events can resolve on the same poll byte: the device's ready bit arriving and the timeout expiring. The bench provokes this by placing the ready byte exactly at the poll byte whose completion first crosses the timeout. It expects the busy code, the same number of poll bytes, and no data bytes on the wire. It also runs a fault on a byte that is both ready and early, and expects the fault code after a single poll byte.

// File: rtl/spihost_pkg.sv
package spihost_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_POLL,
    ST_DATA,
    ST_FIN
  } xstate_e;

  typedef enum logic [1:0] {
    TX_HDR,
    TX_ZERO,
    TX_WDATA
  } txsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       load;
    txsel_e     txSel;
    logic [1:0] hdrIdx;
  } dpcmd_t;

  localparam logic [1:0] ERR_OK    = 2'd0;
  localparam logic [1:0] ERR_BUSY  = 2'd1;
  localparam logic [1:0] ERR_FAULT = 2'd2;

endpackage

// File: rtl/spihost_dpath.sv
module spihost_dpath
  import spihost_pkg::*;
#(
  parameter int         CLK_DIV = 4,
  parameter int         MAX_LEN = 64,
  parameter logic [7:0] ADDR_HI = 8'hD4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpcmd_t                     cmd,
  input  logic                       reqRead,
  input  logic [15:0]                reqAddr,
  input  logic [$clog2(MAX_LEN):0]   reqLen,
  input  logic [7:0]                 wrData,
  input  logic                       miso,
  output logic                       sclk,
  output logic                       mosi,
  output logic                       byteDone,
  output logic [7:0]                 rxByte,
  output logic [$clog2(MAX_LEN)-1:0] lenM1,
  output logic                       isRead
);

  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int DIV_W = $clog2(CLK_DIV) + 1;

  logic             isReadR;
  logic [15:0]      addrR;
  logic [CNT_W-1:0] lenM1R;
  logic [7:0]       shTx;
  logic [7:0]       shRx;
  logic [2:0]       bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             run;
  logic             sclkR;
  logic             byteDoneR;
  logic [7:0]       txByte;

  // byte to launch, chosen by the control strobe
  always_comb begin
    txByte = 8'h00;
    case (cmd.txSel)
      TX_HDR: begin
        case (cmd.hdrIdx)
          2'd0:    txByte = {isReadR, 1'b0, 6'(lenM1R)};
          2'd1:    txByte = ADDR_HI;
          2'd2:    txByte = addrR[15:8];
          default: txByte = addrR[7:0];
        endcase
      end
      TX_WDATA: txByte = wrData;
      default:  txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isReadR   <= 1'b0;
      addrR     <= '0;
      lenM1R    <= '0;
      shTx      <= '0;
      shRx      <= '0;
      bitCnt    <= '0;
      divCnt    <= '0;
      run       <= 1'b0;
      sclkR     <= 1'b0;
      byteDoneR <= 1'b0;
    end else begin
      byteDoneR <= 1'b0;
      if (cmd.capture) begin
        isReadR <= reqRead;
        addrR   <= reqAddr;
        lenM1R  <= CNT_W'(reqLen - 1'b1);
      end
      if (cmd.load) begin
        shTx   <= txByte;
        run    <= 1'b1;
        sclkR  <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (run) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
            shRx  <= {shRx[6:0], miso};
          end else begin
            sclkR <= 1'b0;
            if (bitCnt == 3'd7) begin
              run       <= 1'b0;
              byteDoneR <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              shTx   <= {shTx[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkR;
  assign mosi     = shTx[7];
  assign byteDone = byteDoneR;
  assign rxByte   = shRx;
  assign lenM1    = lenM1R;
  assign isRead   = isReadR;

  // R3: data line held while the clock is high
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclkR && $past(sclkR)) |-> $stable(shTx[7]));

  // R3: control never restarts a byte that is still shifting
  p_no_load_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !run);

endmodule

// File: rtl/spihost_ctrl.sv
module spihost_ctrl
  import spihost_pkg::*;
#(
  parameter int TIMEOUT_CYC = 37_500_000,
  parameter int MAX_LEN     = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       linkFault,
  input  logic                       byteDone,
  input  logic                       rxReady,
  input  logic [$clog2(MAX_LEN)-1:0] lenM1,
  input  logic                       isRead,
  output dpcmd_t                     cmd,
  output logic                       csN,
  output logic                       busy,
  output logic                       doneP,
  output logic [1:0]                 errCode,
  output logic                       rdValid,
  output logic                       wrTake
);

  localparam int CNT_W = $clog2(MAX_LEN);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1) + 1;

  xstate_e          state;
  logic             kick;
  logic [1:0]       hdrIdx;
  logic [CNT_W-1:0] dataCnt;
  logic [TO_W-1:0]  toCnt;
  logic [1:0]       errR;
  logic             doneR;
  logic             toExpired;

  assign toExpired = (toCnt >= TO_W'(TIMEOUT_CYC));

  always_comb begin
    cmd.capture = (state == ST_IDLE) && start;
    cmd.load    = kick;
    cmd.hdrIdx  = hdrIdx;
    if (state == ST_HDR)                 cmd.txSel = TX_HDR;
    else if (state == ST_DATA && !isRead) cmd.txSel = TX_WDATA;
    else                                 cmd.txSel = TX_ZERO;
  end

  assign csN     = (state == ST_IDLE) || (state == ST_FIN);
  assign busy    = (state != ST_IDLE);
  assign doneP   = doneR;
  assign errCode = errR;
  assign rdValid = (state == ST_DATA) && byteDone && isRead;
  assign wrTake  = kick && (state == ST_DATA) && !isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kick    <= 1'b0;
      hdrIdx  <= '0;
      dataCnt <= '0;
      toCnt   <= '0;
      errR    <= ERR_OK;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      kick  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_HDR;
            kick   <= 1'b1;
            hdrIdx <= '0;
            errR   <= ERR_OK;
          end
        end
        ST_HDR: begin
          // returned bits are not inspected during the header
          if (byteDone) begin
            kick <= 1'b1;
            if (hdrIdx == 2'd3) begin
              state <= ST_POLL;
              toCnt <= '0;
            end else begin
              hdrIdx <= hdrIdx + 2'd1;
            end
          end
        end
        ST_POLL: begin
          if (!toExpired) toCnt <= toCnt + 1'b1;
          if (byteDone) begin
            if (linkFault) begin
              errR  <= ERR_FAULT;
              state <= ST_FIN;
            end else if (toExpired) begin
              errR  <= ERR_BUSY;
              state <= ST_FIN;
            end else if (rxReady) begin
              state   <= ST_DATA;
              dataCnt <= '0;
              kick    <= 1'b1;
            end else begin
              kick <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (byteDone) begin
            if (dataCnt == lenM1) begin
              state <= ST_FIN;
            end else begin
              dataCnt <= dataCnt + 1'b1;
              kick    <= 1'b1;
            end
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
          doneR <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: data phase is entered only from a completed ready poll byte
  p_data_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && $past(state) != ST_DATA) |->
      ($past(state) == ST_POLL && $past(rxReady) && $past(byteDone)));

  // R10: completion pulse follows the chip select release
  p_done_cs_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> (csN && $past(state) == ST_FIN));

  // R6: read strobes never exceed the requested count
  p_rd_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (dataCnt <= lenM1));

endmodule

// File: rtl/regbus_spi_host.sv
module regbus_spi_host
  import spihost_pkg::*;
#(
  parameter int         CLK_DIV     = 4,
  parameter int         TIMEOUT_CYC = 37_500_000,
  parameter int         MAX_LEN     = 64,
  parameter logic [7:0] ADDR_HI     = 8'hD4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     reqRead,
  input  logic [15:0]              reqAddr,
  input  logic [$clog2(MAX_LEN):0] reqLen,
  input  logic [7:0]               wrData,
  output logic                     wrTake,
  output logic [7:0]               rdData,
  output logic                     rdValid,
  input  logic                     linkFault,
  output logic                     sclk,
  output logic                     mosi,
  output logic                     csN,
  input  logic                     miso,
  output logic                     busy,
  output logic                     doneP,
  output logic [1:0]               errCode
);

  localparam int CNT_W = $clog2(MAX_LEN);

  dpcmd_t           cmd;
  logic             byteDone;
  logic [7:0]       rxByte;
  logic [CNT_W-1:0] lenM1;
  logic             isRead;

  spihost_dpath #(
    .CLK_DIV (CLK_DIV),
    .MAX_LEN (MAX_LEN),
    .ADDR_HI (ADDR_HI)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .reqRead  (reqRead),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .wrData   (wrData),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .lenM1    (lenM1),
    .isRead   (isRead)
  );

  spihost_ctrl #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .MAX_LEN     (MAX_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .linkFault (linkFault),
    .byteDone  (byteDone),
    .rxReady   (rxByte[0]),
    .lenM1     (lenM1),
    .isRead    (isRead),
    .cmd       (cmd),
    .csN       (csN),
    .busy      (busy),
    .doneP     (doneP),
    .errCode   (errCode),
    .rdValid   (rdValid),
    .wrTake    (wrTake)
  );

  assign rdData = rxByte;

  // R3: clock parked low while deselected
  p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

endmodule

// File: tb/tb_regbus_spi_host.sv
module tb_regbus_spi_host;

  localparam int DIV = 2;
  localparam int TMO = 150;

  typedef struct packed {
    logic        rd;
    logic [15:0] addr;
    logic [6:0]  len;
    logic [3:0]  waitN;
    logic [7:0]  hdrMiso;
    logic [7:0]  readyB;
    logic        fault;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0024, 7'd4,  4'd0, 8'h00, 8'h01, 1'b0},
    '{1'b0, 16'h0F80, 7'd1,  4'd2, 8'hFF, 8'h81, 1'b0},
    '{1'b1, 16'h1234, 7'd64, 4'd3, 8'h01, 8'hFF, 1'b0},
    '{1'b0, 16'h0018, 7'd7,  4'd1, 8'h00, 8'h01, 1'b0},
    '{1'b1, 16'h00F0, 7'd2,  4'd4, 8'h00, 8'h01, 1'b0},
    '{1'b0, 16'h0004, 7'd3,  4'd9, 8'h01, 8'h01, 1'b0},
    '{1'b1, 16'h0100, 7'd5,  4'd0, 8'h00, 8'h01, 1'b1},
    '{1'b0, 16'hABCD, 7'd64, 4'd0, 8'hFF, 8'h01, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic reqRead = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [6:0] reqLen = 7'd1;
  logic [7:0] wrData;
  logic wrTake;
  logic [7:0] rdData;
  logic rdValid;
  logic linkFault = 1'b0;
  logic sclk, mosi, csN;
  logic miso;
  logic busy, doneP;
  logic [1:0] errCode;

  always #10 clk = ~clk;

  regbus_spi_host #(
    .CLK_DIV     (DIV),
    .TIMEOUT_CYC (TMO)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .linkFault(linkFault),
    .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso),
    .busy(busy), .doneP(doneP), .errCode(errCode)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  int cfgWait = 0;
  logic [7:0] cfgHdr = 8'h00;
  logic [7:0] cfgReady = 8'h01;
  logic [7:0] rdBase = 8'h00;
  logic [7:0] wrBase = 8'h00;
  logic [7:0] mosiLog [0:127];
  logic [7:0] txB, rxB;
  logic mosiAtRise;
  int bitIdx = 0;
  int byteIdx = 0;

  function automatic logic [7:0] slaveByte(input int i);
    if (i < 4) return cfgHdr;
    if (i < 4 + cfgWait) return 8'hFE;
    if (i == 4 + cfgWait) return cfgReady;
    return rdBase + 8'(i - 5 - cfgWait);
  endfunction

  initial begin
    miso = 1'b0;
    forever begin
      @(negedge csN);
      bitIdx = 0;
      byteIdx = 0;
      txB = slaveByte(0);
      miso = txB[7];
      while (!csN) begin
        @(negedge sclk or posedge csN);
        if (csN) break;
        bitIdx++;
        if (bitIdx == 8) begin
          if (byteIdx < 128) mosiLog[byteIdx] = rxB;
          byteIdx++;
          bitIdx = 0;
          txB = slaveByte(byteIdx);
        end else begin
          txB = {txB[6:0], 1'b0};
        end
        miso = txB[7];
      end
    end
  end

  always @(posedge sclk) begin
    rxB = {rxB[6:0], mosi};
    mosiAtRise = mosi;
  end

  // monitors, away from the active edge
  int viol = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  int doneCnt = 0;
  int wrIdx = 0;
  bit takeSeen = 0;
  bit doneSeen = 0;
  logic [1:0] doneErr;
  logic doneCs;
  logic [7:0] rdLog [0:63];

  assign wrData = wrBase + 8'(wrIdx);

  always @(negedge clk) begin
    if (takeSeen) wrIdx++;
    takeSeen = wrTake;
    if (wrTake) wrCnt++;
    if (rdValid) begin
      if (rdCnt < 64) rdLog[rdCnt] = rdData;
      rdCnt++;
    end
    if (sclk && (mosi !== mosiAtRise)) viol++;
    if (csN && sclk) viol++;
    if (doneP) begin
      doneSeen = 1;
      doneCnt++;
      doneErr = errCode;
      doneCs = csN;
    end
  end

  function automatic int kAbort();
    for (int k = 1; k < 100; k++)
      if (k * (16 * DIV + 2) - 1 >= TMO) return k;
    return 100;
  endfunction

  task automatic clearMon();
    viol = 0; rdCnt = 0; wrCnt = 0; doneCnt = 0; wrIdx = 0;
    takeSeen = 0; doneSeen = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!doneSeen && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(doneSeen, "R10 done reached", int'(doneSeen), 1);
  endtask

  task automatic runVec(input vec_t v);
    int polls, expErr, base;
    int mism;
    cfgWait = int'(v.waitN);
    cfgHdr = v.hdrMiso;
    cfgReady = v.readyB;
    @(negedge clk);
    clearMon();
    linkFault = v.fault;
    reqRead = v.rd;
    reqAddr = v.addr;
    reqLen = v.len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    linkFault = 1'b0;
    if (v.fault) begin
      polls = 1; expErr = 2;
    end else if (int'(v.waitN) + 1 >= kAbort()) begin
      polls = kAbort(); expErr = 1;
    end else begin
      polls = int'(v.waitN) + 1; expErr = 0;
    end
    // R8 R9 R10: result code
    check(int'(doneErr) == expErr, "R8/R9 errCode", int'(doneErr), expErr);
    check(doneCs == 1'b1, "R10 csN high at doneP", int'(doneCs), 1);
    check(mosiLog[0] == {v.rd, 1'b0, 6'(v.len - 7'd1)}, "R1 header byte0",
          int'(mosiLog[0]), int'({v.rd, 1'b0, 6'(v.len - 7'd1)}));
    check({mosiLog[1], mosiLog[2], mosiLog[3]} == {8'hD4, v.addr}, "R2 address bytes",
          int'({mosiLog[1], mosiLog[2], mosiLog[3]}), int'({8'hD4, v.addr}));
    // R4 R5: poll count follows from total bytes on the wire
    check(byteIdx == 4 + polls + (expErr == 0 ? int'(v.len) : 0), "R4/R5 byte total",
          byteIdx, 4 + polls + (expErr == 0 ? int'(v.len) : 0));
    mism = 0;
    for (int j = 0; j < polls; j++) if (mosiLog[4 + j] != 8'h00) mism++;
    check(mism == 0, "R4 poll MOSI zero", mism, 0);
    check(viol == 0, "R3 mode0 timing", viol, 0);
    base = 4 + polls;
    mism = 0;
    if (expErr != 0) begin
      check(rdCnt == 0 && wrCnt == 0, "R8 no data on abort", rdCnt + wrCnt, 0);
    end else if (v.rd) begin
      check(rdCnt == int'(v.len), "R6 read count", rdCnt, int'(v.len));
      for (int j = 0; j < int'(v.len); j++) begin
        if (rdLog[j] != rdBase + 8'(j)) mism++;
        if (mosiLog[base + j] != 8'h00) mism++;
      end
      check(mism == 0, "R6 read data", mism, 0);
    end else begin
      check(wrCnt == int'(v.len), "R7 wrTake count", wrCnt, int'(v.len));
      for (int j = 0; j < int'(v.len); j++)
        if (mosiLog[base + j] != wrBase + 8'(j)) mism++;
      check(mism == 0, "R7 write data", mism, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state
    check(csN == 1'b1 && sclk == 1'b0, "R11 reset pins", int'({csN, sclk}), 2);
    check(busy == 1'b0 && doneP == 1'b0, "R11 reset status", int'({busy, doneP}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && busy == 1'b0, "R11 after reset", int'({csN, busy}), 2);

    for (int i = 0; i < NV; i++) begin
      rdBase = 8'hA0 + 8'(i);
      wrBase = 8'h30 + 8'(i * 8);
      runVec(VECS[i]);
    end

    // R12: start while busy is ignored
    cfgWait = 0; cfgHdr = 8'h00; cfgReady = 8'h01; rdBase = 8'h55;
    @(negedge clk);
    clearMon();
    reqRead = 1'b1; reqAddr = 16'h0C0C; reqLen = 7'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(busy == 1'b1, "R12 busy mid-transfer", int'(busy), 1);
    reqRead = 1'b0; reqAddr = 16'h7777; reqLen = 7'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (200) @(negedge clk);
    check(doneCnt == 1, "R12 single completion", doneCnt, 1);
    check({mosiLog[0], mosiLog[2], mosiLog[3]} == 24'h810C0C, "R12 header unchanged",
          int'({mosiLog[0], mosiLog[2], mosiLog[3]}), 24'h810C0C);
    check(byteIdx == 7 && rdCnt == 2, "R12 byte total", byteIdx, 7);
    check(csN == 1'b1 && busy == 1'b0, "R12 stays idle", int'({csN, busy}), 2);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule